// File: doc/BRIEF.md
# Lock-Qualified Reset Pulse Stretcher

This block drives one processor reset line that also shows whether a clock-generation loop has locked. While the loop is unlocked, the line is pulled low. Once lock is reached, the line stays low for a fixed number of system-clock cycles and is then released. A software- or board-level reset request, which is active low, can pull the line low again at any time after lock. The line is then held low for the same stretch, counted from the moment the request returns high.

The line is open drain. The block never drives it high. It presents a pull-down request, which is active low, together with an output enable. When the block releases the line, the enable is off and an external pull-up makes the line read high.

The stretch is counted on the system clock. That clock keeps running and stays locked while the reset is active, so the count is exact. The lock status and the reset request arrive asynchronously. Each one is resynchronised before the block uses it.

Top module: `rst_stretch_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block pulls the line low after that edge: `line_oe` = 1 and `line_drive_n` = 0. In every cycle, `line_drive_n` is the inverse of `line_oe`.
- R2: While the synchronised lock status is low, the line is pulled low, whatever the request input does.
- R3: At power-up with `req_n` high, the line stays low for exactly HOLD_CYCLES + 2 clock edges after the first edge that samples `lock_in` high. It is released on the next edge. The extra 2 edges are the synchroniser latency.
- R4: If `req_n` is low when lock is reached, the line stays low for as long as `req_n` stays low, even though the loop is locked.
- R5: After release, `req_n` going low pulls the line low within 3 clock edges. The line is released HOLD_CYCLES + 2 edges after the first edge that samples `req_n` high again.
- R6: If `req_n` goes low again while the hold count is running, the count restarts. Release then follows HOLD_CYCLES + 2 edges after the later rising edge of `req_n`.
- R7: If lock is lost in any state, the line is pulled low within 3 clock edges and the hold count is cleared. When lock returns, a full HOLD_CYCLES stretch is counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System-rate clock, twice the reference rate |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| lock_in | input | 1 | Asynchronous loop-lock status, high when locked |
| req_n | input | 1 | Asynchronous reset request, active low |
| line_drive_n | output | 1 | Pull-down request for the open-drain line, 0 = pull low |
| line_oe | output | 1 | Output enable for the line driver, 0 = high impedance |

## Verification
The bench builds the block with HOLD_CYCLES = 16 and SYNC_STAGES = 2. The short hold lets every complete stretch, and every restart in the middle of a stretch, finish within a few dozen cycles. This makes it cheap to measure the exact release edge many times. The release edges covered are after power-up, after a request pulse, after a retrigger and after relock. With the two-stage synchroniser at its default depth, the HOLD_CYCLES + 2 latency the requirements state can be observed directly at the ports.

// File: rtl/rst_stretch_pkg.sv
// Package: shared types for the reset pulse stretcher.
// Assumes nothing beyond IEEE 1800-2017.
package rst_stretch_pkg;

    // Line control states, from most to least restrictive.
    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,  // loop not locked, line pulled low
        ST_HELD     = 2'd1,  // locked, request asserted, line pulled low
        ST_COUNT    = 2'd2,  // locked, request released, hold timer running
        ST_RELEASED = 2'd3   // hold expired, line high impedance
    } stretch_state_e;

endpackage

// File: rtl/rst_stretch_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes the input level is stable for at least STAGES clock periods
// when it matters. Resets synchronously to RST_VAL.
module rst_stretch_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES < 2) begin : g_single
            logic q;

            // Single-flop capture for the reduced-depth variant.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] chain;

            // Shift the sampled level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
            assign dout = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rst_stretch_timer.sv
// Module: hold-interval counter.
// Counts clock edges while run is high and flags the last cycle of the
// interval with done. Any cycle with run low clears the count to zero.
// Assumes HOLD_CYCLES >= 2.
module rst_stretch_timer #(
    parameter int HOLD_CYCLES = 1024,
    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          done
);

    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    // The final counted cycle of the hold interval.
    assign done = run && (cnt == LAST);

    // Advance while running; wrap to zero on done or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || done) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R3: the count never passes the last cycle of the interval.
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6: an interrupted run starts the next interval from zero.
    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/rst_stretch_ctrl.sv
// Module: line control state machine.
// Works on the synchronised lock status and request. It decides whether
// the open-drain line is pulled low, and it gates the hold timer.
// Assumes both inputs are already synchronous to clk.
module rst_stretch_ctrl
    import rst_stretch_pkg::*;
#(
    parameter int HOLD_CYCLES = 1024,
    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          locked,
    input  logic          req_idle,
    input  logic [CW-1:0] cnt,
    input  logic          done,
    output logic          run,
    output logic          pull_low
);

    stretch_state_e state, state_nx;

    // The timer runs only in the counting state with lock held and no request.
    assign run = (state == ST_COUNT) && locked && req_idle;

    // Next-state selection. Loss of lock overrides everything else.
    always_comb begin
        state_nx = state;
        if (!locked) begin
            state_nx = ST_UNLOCKED;
        end else begin
            unique case (state)
                ST_UNLOCKED: state_nx = req_idle ? ST_COUNT : ST_HELD;
                ST_HELD:     state_nx = req_idle ? ST_COUNT : ST_HELD;
                ST_COUNT: begin
                    if (!req_idle) state_nx = ST_HELD;
                    else if (done) state_nx = ST_RELEASED;
                end
                ST_RELEASED: state_nx = req_idle ? ST_RELEASED : ST_HELD;
                default:     state_nx = ST_UNLOCKED;
            endcase
        end
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_UNLOCKED;
        else        state <= state_nx;
    end

    // The line is released only once the full hold interval has expired.
    assign pull_low = (state != ST_RELEASED);

    // R2: an unlocked loop always leads to a pulled-low line.
    p_unlocked_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> pull_low);

    // R4: an active request keeps the line low.
    p_req_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !req_idle) |=> (state == ST_HELD));

    // R3: the line is released only from the final counted cycle.
    p_release_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_RELEASED) && !done) |=> pull_low);

    // R7: lock loss clears the hold count.
    p_lockloss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (cnt == '0));

endmodule

// File: rtl/rst_stretch_top.sv
// Module: lock-qualified reset pulse stretcher, top level.
// Synchronises the lock status and the request, runs the control FSM and
// the hold timer, and presents an open-drain style output: a low-active
// pull-down request plus an output enable. The line is never driven high.
// Assumes clk keeps running through reset and request pulses last at
// least SYNC_STAGES clock periods.
module rst_stretch_top #(
    parameter int HOLD_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    input  logic req_n,
    output logic line_drive_n,
    output logic line_oe
);

    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;

    logic          locked;
    logic          req_idle;
    logic          run;
    logic          done;
    logic          pull_low;
    logic [CW-1:0] cnt;

    rst_stretch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
        .clk(clk), .rst_n(rst_n), .din(lock_in), .dout(locked)
    );

    rst_stretch_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .din(req_n), .dout(req_idle)
    );

    rst_stretch_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .done(done)
    );

    rst_stretch_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .locked(locked), .req_idle(req_idle),
        .cnt(cnt), .done(done), .run(run), .pull_low(pull_low)
    );

    // Open-drain presentation: enable the driver only to pull low.
    assign line_oe      = pull_low;
    assign line_drive_n = ~pull_low;

    // R1: the two driver controls never disagree.
    p_driver_pair_r1: assert property (@(posedge clk)
        line_oe != line_drive_n);

endmodule

// File: tb/tb_rst_stretch_top.sv
module tb_rst_stretch_top;

    localparam int HOLD = 16;
    localparam int LAT  = HOLD + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_in = 1'b0;
    logic req_n = 1'b1;
    logic line_drive_n;
    logic line_oe;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    // Reference model state: sampled-input queues and the phase of the line.
    bit lk_q[$];
    bit rq_q[$];
    int m_phase = 0;   // 0 unlocked, 1 held, 2 counting, 3 released
    int m_count = 0;

    rst_stretch_top #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .req_n(req_n),
        .line_drive_n(line_drive_n), .line_oe(line_oe)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp_v, cycles);
        end
    endtask

    // Behavioural model: inputs seen two edges late, then the line phase.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            lk_q = '{1'b0, 1'b0};
            rq_q = '{1'b0, 1'b0};
            m_phase = 0;
            m_count = 0;
        end else begin
            bit lk_seen;
            bit rq_seen;
            lk_seen = lk_q[0];
            rq_seen = rq_q[0];
            void'(lk_q.pop_front());
            void'(rq_q.pop_front());
            lk_q.push_back(lock_in);
            rq_q.push_back(req_n);
            if (!lk_seen) begin
                m_phase = 0;
                m_count = 0;
            end else if (!rq_seen) begin
                m_phase = 1;
                m_count = 0;
            end else if (m_phase == 0 || m_phase == 1) begin
                m_phase = 2;
                m_count = 1;
            end else if (m_phase == 2) begin
                if (m_count == HOLD) begin
                    m_phase = 3;
                    m_count = 0;
                end else begin
                    m_count++;
                end
            end
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!finished && cycles > 0) begin
            int exp_low;
            exp_low = (m_phase != 3) ? 1 : 0;
            check({cur_req, " model line_oe"}, int'(line_oe), exp_low);
            check("R1 driver pair", int'(line_drive_n), 1 - exp_low);
        end
    end

    // Count the low samples that follow an input change made at a negedge.
    task automatic measure_low(output int n);
        n = 0;
        for (int i = 0; i < 4 * HOLD + 20; i++) begin
            @(negedge clk);
            if (!line_oe) break;
            n++;
        end
    endtask

    task automatic wait_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure but still reaches the summary.
    always @(posedge clk) begin
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state.
        cur_req = "R1";
        wait_cycles(3);
        check("R1 reset oe", int'(line_oe), 1);
        check("R1 reset drive_n", int'(line_drive_n), 0);
        rst_n = 1'b1;

        // R2: no lock for a long time, request toggling.
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            req_n = i[2];
            check("R2 unlocked low", int'(line_oe), 1);
        end
        req_n = 1'b1;
        wait_cycles(4);

        // R3: lock reached with request idle.
        cur_req = "R3";
        @(negedge clk);
        lock_in = 1'b1;
        measure_low(n);
        check("R3 power-up stretch", n, LAT);
        wait_cycles(5);
        check("R3 released", int'(line_oe), 0);

        // R4: request held low through power-up.
        cur_req = "R4";
        @(negedge clk);
        rst_n = 1'b0;
        lock_in = 1'b0;
        req_n = 1'b0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(3);
        lock_in = 1'b1;
        wait_cycles(3 * HOLD);
        check("R4 held after lock", int'(line_oe), 1);
        req_n = 1'b1;
        measure_low(n);
        check("R4 stretch after release", n, LAT);

        // R5: request pulse after release.
        cur_req = "R5";
        wait_cycles(4);
        req_n = 1'b0;
        wait_cycles(3);
        check("R5 pulled low quickly", int'(line_oe), 1);
        wait_cycles(2);
        req_n = 1'b1;
        measure_low(n);
        check("R5 stretch length", n, LAT);

        // R6: retrigger in the middle of the count.
        cur_req = "R6";
        wait_cycles(4);
        req_n = 1'b0;
        wait_cycles(3);
        req_n = 1'b1;
        wait_cycles(HOLD / 2);
        check("R6 still low mid-count", int'(line_oe), 1);
        req_n = 1'b0;
        wait_cycles(3);
        req_n = 1'b1;
        measure_low(n);
        check("R6 restarted stretch", n, LAT);

        // R7: lock loss while released, then relock.
        cur_req = "R7";
        wait_cycles(4);
        lock_in = 1'b0;
        wait_cycles(3);
        check("R7 low after lock loss", int'(line_oe), 1);
        wait_cycles(5);
        lock_in = 1'b1;
        measure_low(n);
        check("R7 full stretch after relock", n, LAT);

        // R7: lock loss mid-count clears the count.
        wait_cycles(4);
        req_n = 1'b0;
        wait_cycles(3);
        req_n = 1'b1;
        wait_cycles(HOLD - 2);
        lock_in = 1'b0;
        wait_cycles(4);
        lock_in = 1'b1;
        measure_low(n);
        check("R7 count cleared on lock loss", n, LAT);
        wait_cycles(3);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule